// File: doc/BRIEF.md
# Accumulator Decimal-Adjust and Unary Flag Unit

This unit performs the one-byte accumulator and carry operations of an 8-bit processor core: decimal adjust after BCD arithmetic, one's complement, two's-complement negate, carry complement and carry set. For each operation it takes the current accumulator and the current flag byte and returns the new accumulator and the new flag byte. The decoder picks the operation with a 3-bit select. Instruction fetch, decode and the general adder stay outside this unit.

Decimal adjust reads the subtract flag left by the previous arithmetic operation. That flag decides whether the unit corrects a BCD sum or a BCD difference. The half-carry flag, the carry flag and the two nibble values then choose the correction constant. With the default parameter the results are registered, so they appear one clock after the inputs. A parameter can also make the unit purely combinational.

The flag byte holds, from bit 7 down to bit 0: sign, zero, 0, half-carry, 0, parity/overflow, subtract, carry.

Top module: `acc_adjust_unit`

## Requirements
- R1: Decimal adjust with subtract flag (bit 1) clear adds 06h when the low nibble is above 9 or half-carry (bit 4) is set. The new half-carry is 1 exactly when the low nibble was above 9.
- R2: Decimal adjust with subtract flag clear adds 60h when carry (bit 0) is set or the accumulator is above 99h. Both corrections together add 66h. The new carry is 1 exactly when 60h was included.
- R3: Decimal adjust with subtract flag set subtracts 06h when half-carry is set and 60h when carry is set. Carry and the subtract flag are unchanged. The new half-carry is the old half-carry AND (low nibble below 6).
- R4: Decimal adjust sets sign (bit 7) to result bit 7, zero (bit 6) when the result is 00h, and parity (bit 2) when the result has an even number of ones. Binary sum 3Ch with no flags set gives 42h.
- R5: Op 1 (complement) inverts all eight accumulator bits. It sets half-carry and subtract and keeps sign, zero, parity and carry.
- R6: Op 2 (negate) returns 00h minus A, so 80h stays 80h. Parity/overflow is set only for A=80h and carry only for A not 00h. Half-carry is set when the low nibble of A is not 0. Subtract is set, and sign and zero follow the result.
- R7: Op 3 (complement carry) inverts carry, copies the old carry into half-carry, clears subtract, and keeps sign, zero, parity and the accumulator.
- R8: Op 4 (set carry) sets carry, clears half-carry and subtract, and keeps sign, zero, parity and the accumulator.
- R9: Op 0 is decimal adjust. Op codes 5 to 7 return the accumulator and flags unchanged. Output flag bits 5 and 3 are always 0.
- R10: With REG_OUT=1 the outputs change one clock after the inputs. While rst_n is low at a clock edge both outputs become 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation select (0 adjust, 1 complement, 2 negate, 3 complement carry, 4 set carry) |
| acc_i | input | 8 | Current accumulator |
| flags_i | input | 8 | Current flag byte |
| acc_o | output | 8 | New accumulator |
| flags_o | output | 8 | New flag byte |

## Verification
The bench sweeps every operation over all 256 accumulator values and all eight combinations of carry, half-carry and subtract. It also runs random vectors whose sign, zero and parity inputs are random, which catches any kept flag that is recomputed by mistake.

Several corner cases get direct attention:
- A=9Ah after an addition with no carry. A design that checks only the high nibble misses the 60h correction and leaves carry clear.
- Subtract-direction adjusts with half-carry set and a low nibble of 6 or more. Here a wrong half-carry rule leaves bit 4 set.
- Negate of 00h and 80h. These expose a carry or overflow rule written the wrong way round.
- The 3Ch to 42h example from the requirements.

// File: rtl/acc_adj_pkg.sv
// Package: shared operation codes and flag-byte layout for the
// accumulator adjust unit. Assumes an 8-bit accumulator.
package acc_adj_pkg;
    localparam int ACC_W = 8;
    localparam int NIB_W = ACC_W / 2;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_DAA = 3'd0,
        OP_CPL = 3'd1,
        OP_NEG = 3'd2,
        OP_CCF = 3'd3,
        OP_SCF = 3'd4
    } acc_op_e;

    // flag byte, bit 7 down to bit 0
    typedef struct packed {
        logic s;
        logic z;
        logic rsv5;
        logic h;
        logic rsv3;
        logic pv;
        logic n;
        logic c;
    } flag_t;
endpackage

// File: rtl/daa_core.sv
// Module: daa_core
// Decimal adjust of the accumulator after a BCD add or subtract.
// Assumes the subtract flag describes the previous operation.
// Produces only the data result and the new H and C flags.
module daa_core
    import acc_adj_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    input  logic             h_i,
    input  logic             n_i,
    input  logic             c_i,
    output logic [ACC_W-1:0] res_o,
    output logic             h_o,
    output logic             c_o
);
    localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
    localparam logic [NIB_W-1:0] NIB_FIX   = NIB_W'(6);
    localparam logic [ACC_W-1:0] BYTE_MAX  = ACC_W'(8'h99);

    logic [NIB_W-1:0] lo_nib;
    logic             lo_big;
    logic             byte_big;
    logic             fix_lo;
    logic             fix_hi;
    logic [ACC_W-1:0] corr;

    assign lo_nib   = acc_i[NIB_W-1:0];
    assign lo_big   = lo_nib > DIGIT_MAX;
    assign byte_big = acc_i > BYTE_MAX;

    // choose which nibbles need the six-offset correction
    always_comb begin
        if (n_i) begin
            fix_lo = h_i;
            fix_hi = c_i;
        end else begin
            fix_lo = lo_big | h_i;
            fix_hi = byte_big | c_i;
        end
    end

    // build correction constant and apply it in the right direction
    always_comb begin
        corr  = {(fix_hi ? NIB_FIX : '0), (fix_lo ? NIB_FIX : '0)};
        res_o = n_i ? (acc_i - corr) : (acc_i + corr);
    end

    // new half-carry and carry
    always_comb begin
        if (n_i) begin
            h_o = h_i & (lo_nib < NIB_FIX);
            c_o = c_i;
        end else begin
            h_o = lo_big;
            c_o = fix_hi;
        end
    end
endmodule

// File: rtl/unary_ops.sv
// Module: unary_ops
// Complement, negate, complement-carry and set-carry, plus the
// pass-through for undefined selects. Assumes decimal adjust is
// handled elsewhere; its select yields a pass-through here.
module unary_ops
    import acc_adj_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic [ACC_W-1:0] acc_i,
    input  flag_t            flg_i,
    output logic [ACC_W-1:0] res_o,
    output flag_t            flg_o
);
    logic [ACC_W-1:0] neg_res;
    localparam logic [ACC_W-1:0] MIN_NEG = ACC_W'(1) << (ACC_W - 1);

    assign neg_res = '0 - acc_i;

    // per-operation result and flag rules
    always_comb begin
        res_o      = acc_i;
        flg_o      = flg_i;
        flg_o.rsv5 = 1'b0;
        flg_o.rsv3 = 1'b0;
        case (op_i)
            OP_CPL: begin
                res_o   = ~acc_i;
                flg_o.h = 1'b1;
                flg_o.n = 1'b1;
            end
            OP_NEG: begin
                res_o    = neg_res;
                flg_o.s  = neg_res[ACC_W-1];
                flg_o.z  = (neg_res == '0);
                flg_o.h  = (acc_i[NIB_W-1:0] != '0);
                flg_o.pv = (acc_i == MIN_NEG);
                flg_o.n  = 1'b1;
                flg_o.c  = (acc_i != '0);
            end
            OP_CCF: begin
                flg_o.h = flg_i.c;
                flg_o.n = 1'b0;
                flg_o.c = ~flg_i.c;
            end
            OP_SCF: begin
                flg_o.h = 1'b0;
                flg_o.n = 1'b0;
                flg_o.c = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/out_stage.sv
// Module: out_stage
// Optional output register. REG_OUT=1 adds one clock of latency
// with a synchronous active-low clear; REG_OUT=0 is a wire.
module out_stage #(
    parameter bit REG_OUT = 1'b1,
    parameter int W       = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0] q_r;
            // capture the result, clear it under reset
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_wire
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/acc_adjust_unit.sv
// Module: acc_adjust_unit (top)
// Accumulator decimal adjust and unary carry/complement operations.
// Assumes flags_i uses the layout S Z 0 H 0 PV N C (bit 7..0).
// Output is registered when REG_OUT=1 (default).
module acc_adjust_unit
    import acc_adj_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] flags_i,
    output logic [ACC_W-1:0] acc_o,
    output logic [ACC_W-1:0] flags_o
);
    localparam int OUT_W = 2 * ACC_W;

    flag_t            flg_in;
    logic [ACC_W-1:0] daa_res;
    logic             daa_h;
    logic             daa_c;
    logic [ACC_W-1:0] un_res;
    flag_t            un_flg;
    logic [ACC_W-1:0] nxt_acc;
    flag_t            nxt_flg;

    assign flg_in = flag_t'(flags_i);

    daa_core u_daa (
        .acc_i (acc_i),
        .h_i   (flg_in.h),
        .n_i   (flg_in.n),
        .c_i   (flg_in.c),
        .res_o (daa_res),
        .h_o   (daa_h),
        .c_o   (daa_c)
    );

    unary_ops u_un (
        .op_i  (op_i),
        .acc_i (acc_i),
        .flg_i (flg_in),
        .res_o (un_res),
        .flg_o (un_flg)
    );

    // select the producing unit and pack decimal-adjust flags
    always_comb begin
        if (op_i == OP_DAA) begin
            nxt_acc      = daa_res;
            nxt_flg      = '0;
            nxt_flg.s    = daa_res[ACC_W-1];
            nxt_flg.z    = (daa_res == '0);
            nxt_flg.h    = daa_h;
            nxt_flg.pv   = ~^daa_res;
            nxt_flg.n    = flg_in.n;
            nxt_flg.c    = daa_c;
        end else begin
            nxt_acc = un_res;
            nxt_flg = un_flg;
        end
    end

    out_stage #(.REG_OUT(REG_OUT), .W(OUT_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({nxt_acc, nxt_flg}),
        .q_o   ({acc_o, flags_o})
    );

    generate
        if (REG_OUT) begin : g_chk_reg
            // R9
            rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0));
            // R5
            cpl_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_CPL) |=> (acc_o == ~$past(acc_i)) && flags_o[4] && flags_o[1]);
            // R6
            neg_sum_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_NEG) |=> (ACC_W'(acc_o + $past(acc_i)) == '0) && flags_o[1]);
            // R7
            ccf_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_CCF) |=> (flags_o[0] != $past(flags_i[0]))
                                     && (flags_o[4] == $past(flags_i[0])));
            // R8
            scf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_SCF) |=> flags_o[0] && !flags_o[4] && !flags_o[1]);
            // R3
            daa_sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_DAA && flags_i[1]) |=> (flags_o[0] == $past(flags_i[0])) && flags_o[1]);
        end else begin : g_chk_comb
            // R5
            cpl_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_CPL) |-> (acc_o == ~acc_i) && flags_o[4] && flags_o[1]);
            // R8
            scf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_SCF) |-> flags_o[0] && !flags_o[4] && !flags_o[1]);
            // R7
            ccf_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_CCF) |-> (flags_o[0] != flags_i[0]) && (flags_o[4] == flags_i[0]));
            // R9
            rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0));
        end
    endgenerate
endmodule

// File: tb/tb_acc_adjust_unit.sv
// Bench for acc_adjust_unit with default REG_OUT=1 (one clock latency).
module tb_acc_adjust_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] flags_i = 8'h00;
    logic [7:0] acc_o;
    logic [7:0] flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    acc_adjust_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
        .flags_i(flags_i), .acc_o(acc_o), .flags_o(flags_o)
    );

    // reference: returns {acc, flags} from the requirements
    function automatic logic [15:0] ref_model(input logic [2:0] op,
                                              input logic [7:0] a,
                                              input logic [7:0] f);
        logic s, z, h, pv, n, c;
        logic [7:0] r;
        logic [7:0] k;
        s = f[7]; z = f[6]; h = f[4]; pv = f[2]; n = f[1]; c = f[0];
        r = a;
        case (op)
            3'd0: begin
                k = 8'h00;
                if (!n) begin
                    if (a[3:0] > 4'd9 || h) k[3:0] = 4'h6;
                    if (a > 8'h99 || c) k[7:4] = 4'h6;
                    r = a + k;
                    h = (a[3:0] > 4'd9);
                    c = (k[7:4] != 4'h0);
                end else begin
                    if (h) k[3:0] = 4'h6;
                    if (c) k[7:4] = 4'h6;
                    r = a - k;
                    h = h && (a[3:0] < 4'd6);
                end
                s = r[7]; z = (r == 8'h00);
                pv = ($countones(r) % 2 == 0);
            end
            3'd1: begin r = ~a; h = 1'b1; n = 1'b1; end
            3'd2: begin
                r = 8'h00 - a; s = r[7]; z = (r == 8'h00);
                h = (a[3:0] != 4'h0); pv = (a == 8'h80); n = 1'b1;
                c = (a != 8'h00);
            end
            3'd3: begin h = c; c = ~c; n = 1'b0; end
            3'd4: begin h = 1'b0; c = 1'b1; n = 1'b0; end
            default: ;
        endcase
        return {r, s, z, 1'b0, h, 1'b0, pv, n, c};
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic n);
        case (op)
            3'd0:    return n ? "R3 R4" : "R1 R2 R4";
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R7";
            3'd4:    return "R8";
            default: return "R9";
        endcase
    endfunction

    // drive at a falling edge, compare one falling edge later (R10 latency)
    task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] f);
        logic [15:0] exp;
        op_i = op; acc_i = a; flags_i = f;
        exp = ref_model(op, a, f);
        @(negedge clk);
        checks++;
        if ({acc_o, flags_o} !== exp) begin
            errors++;
            $display("FAIL %s R10 op=%0d a=%h f=%h: got acc=%h flags=%h expected acc=%h flags=%h",
                     tag_of(op, f[1]), op, a, f, acc_o, flags_o, exp[15:8], exp[7:0]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd20240611;
        // reset clears outputs (R10)
        op_i = 3'd1; acc_i = 8'h5A; flags_i = 8'hFF;
        repeat (3) @(negedge clk);
        checks++;
        if (acc_o !== 8'h00 || flags_o !== 8'h00) begin
            errors++;
            $display("FAIL R10 reset: got %h/%h expected 00/00", acc_o, flags_o);
        end
        rst_n = 1'b1;

        // directed: 15+27 binary sum 3C -> 42 (R4)
        apply(3'd0, 8'h3C, 8'h00);
        // above 99 with no carry (R2)
        apply(3'd0, 8'h9A, 8'h00);
        // subtract with H set and low nibble >= 6 (R3)
        apply(3'd0, 8'h0F, 8'h13);
        // negate corner values (R6)
        apply(3'd2, 8'h00, 8'h00);
        apply(3'd2, 8'h80, 8'h00);
        // reserved bits set on input must come out clear (R9)
        apply(3'd7, 8'hA5, 8'hFF);

        // exhaustive sweep over op, accumulator, and C/H/N
        for (int op = 0; op < 8; op++) begin
            for (int hcn = 0; hcn < 8; hcn++) begin
                for (int a = 0; a < 256; a++) begin
                    logic [7:0] f;
                    f = {1'b0, 1'b0, 1'b0, hcn[2], 1'b0, 1'b0, hcn[1], hcn[0]};
                    apply(op[2:0], a[7:0], f);
                end
            end
        end

        // random vectors including S, Z, PV and reserved inputs
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] rv;
            rv = $urandom(seed);
            seed = seed + 32'd7919;
            apply(rv[2:0], rv[15:8], rv[23:16]);
        end

        // reset asserted mid-run clears both outputs (R10)
        rst_n = 1'b0;
        op_i = 3'd4; acc_i = 8'hFF; flags_i = 8'hFF;
        @(negedge clk);
        checks++;
        if (acc_o !== 8'h00 || flags_o !== 8'h00) begin
            errors++;
            $display("FAIL R10 mid-run reset: got %h/%h expected 00/00", acc_o, flags_o);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule